// File: doc/BRIEF.md
# GPIO Alternate-Function Commit Guard

This block protects the alternate-function select of an 8-bit GPIO port against stray writes. It holds three pieces of state: a lock flag, an 8-bit commit mask and the 8-bit alternate-function select itself. The commit mask decides, bit by bit, which alternate-function bits a later write may change. The mask itself can only be rewritten after software has written a fixed 32-bit key to the lock register.

Software reaches the block over a plain register bus: a byte address, a write strobe, write data and combinational read data. The current alternate-function select also drives the `alt_sel` output towards the pad multiplexers. A typical sequence is: write the key to unlock, write a new commit mask, then write the lock register with any other value to close the guard again.

Top module: `gpio_commit_guard`

## Requirements
- R1: A write of exactly 32'h0ACCE551 to the lock register (byte offset 0x520) clears the lock flag, so the unit becomes unlocked.
- R2: A write of any other 32-bit value to the lock register sets the lock flag. This includes values that differ from the key only in the upper bits or only in bit 0.
- R3: A read at offset 0x520 returns 1 in bit 0 while locked and 0 while unlocked. All other read bits are 0.
- R4: A write at offset 0x524 stores bits [7:0] of the write data into the commit mask only while the unit is unlocked. A read at 0x524 returns the mask in bits [7:0].
- R5: A write at offset 0x420 updates only those alternate-function bits whose commit-mask bit is 1. The other bits keep their value. A read at 0x420 returns the register in bits [7:0].
- R6: Reset (synchronous, active high) leaves the unit locked, the commit mask at 8'hFF and the alternate-function register at 8'h00.
- R7: Once unlocked, the unit stays unlocked until the next write to the lock register. Writes to the commit register or the alternate-function register do not relock it.
- R8: A write to any address other than 0x520, 0x524 and 0x420 leaves the lock flag, the commit mask and the alternate-function register unchanged.
- R9: The `alt_sel` output always equals the stored alternate-function register.
- R10: A read at any address other than the three registers returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| alt_sel | output | 8 | Current alternate-function select |

## Verification
On every cycle the assertions check the following:
- The key compare sets the lock flag correctly after any lock-register write.
- The commit mask never moves unless an unlocked commit write occurs.
- An alternate-function write never changes a bit that was masked off.
- The lock flag and the alternate-function register stay stable when their strobes are idle.
- The reset values are in place.

Some properties can only be shown by the bench's scenarios:
- The read-back encoding at each offset, and the zeros at unmapped offsets.
- The key only matches on an exact 32-bit value; near-miss keys lock the unit.
- A mask that was committed earlier shapes later alternate-function writes correctly across lock and unlock sequences.

// File: rtl/gcg_pkg.sv
package gcg_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int PORT_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ALT    = 12'h420;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 12'h524;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;

  // Merge new bits into old ones where the enable mask is 1.
  function automatic logic [PORT_W-1:0] masked_merge(
    input logic [PORT_W-1:0] old_v,
    input logic [PORT_W-1:0] new_v,
    input logic [PORT_W-1:0] en);
    return (old_v & ~en) | (new_v & en);
  endfunction

  // Only an exact full-width match counts as the key.
  function automatic logic key_match(input logic [DATA_W-1:0] v);
    return v == UNLOCK_KEY;
  endfunction
endpackage

// File: rtl/gcg_decode.sv
module gcg_decode
  import gcg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit_lock,
  output logic              hit_commit,
  output logic              hit_alt,
  output logic              wr_lock,
  output logic              wr_commit,
  output logic              wr_alt
);
  always_comb begin
    hit_lock   = (addr == OFS_LOCK);
    hit_commit = (addr == OFS_COMMIT);
    hit_alt    = (addr == OFS_ALT);
    wr_lock    = wr && hit_lock;
    wr_commit  = wr && hit_commit;
    wr_alt     = wr && hit_alt;
  end
endmodule

// File: rtl/gcg_key_lock.sv
module gcg_key_lock
  import gcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lock,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  always_ff @(posedge clk) begin
    if (rst)          locked <= 1'b1;
    else if (wr_lock) locked <= !key_match(wdata);
  end
endmodule

// File: rtl/gcg_masked_reg.sv
module gcg_masked_reg #(
  parameter int           W     = 8,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_V;
    else if (we) q <= (q & ~mask) | (wdata & mask);
  end
endmodule

// File: rtl/gpio_commit_guard.sv
module gpio_commit_guard
  import gcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] alt_sel
);
  localparam int PAD_W = DATA_W - PORT_W;

  logic hit_lock, hit_commit, hit_alt;
  logic wr_lock, wr_commit, wr_alt;
  logic locked;
  logic commit_we;
  logic [PORT_W-1:0] commit_q;
  logic [PORT_W-1:0] alt_q;

  gcg_decode u_dec (
    .addr(bus_addr), .wr(bus_wr),
    .hit_lock(hit_lock), .hit_commit(hit_commit), .hit_alt(hit_alt),
    .wr_lock(wr_lock), .wr_commit(wr_commit), .wr_alt(wr_alt)
  );

  gcg_key_lock u_lock (
    .clk(clk), .rst(rst), .wr_lock(wr_lock), .wdata(bus_wdata), .locked(locked)
  );

  assign commit_we = wr_commit && !locked;

  gcg_masked_reg #(.W(PORT_W), .RST_V({PORT_W{1'b1}})) u_commit (
    .clk(clk), .rst(rst), .we(commit_we), .mask({PORT_W{1'b1}}),
    .wdata(bus_wdata[PORT_W-1:0]), .q(commit_q)
  );

  gcg_masked_reg #(.W(PORT_W), .RST_V('0)) u_alt (
    .clk(clk), .rst(rst), .we(wr_alt), .mask(commit_q),
    .wdata(bus_wdata[PORT_W-1:0]), .q(alt_q)
  );

  assign alt_sel = alt_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_lock)        bus_rdata = {{(DATA_W-1){1'b0}}, locked};
    else if (hit_commit) bus_rdata = {{PAD_W{1'b0}}, commit_q};
    else if (hit_alt)    bus_rdata = {{PAD_W{1'b0}}, alt_q};
  end
endmodule

// File: rtl/gcg_checker.sv
module gcg_checker
  import gcg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              wr_lock,
  input logic              wr_commit,
  input logic              wr_alt,
  input logic              locked,
  input logic [PORT_W-1:0] commit_q,
  input logic [PORT_W-1:0] alt_q,
  input logic [PORT_W-1:0] alt_sel
);
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && bus_wdata == 32'h0ACC_E551) |=> !locked); // R1
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (wr_lock && bus_wdata != 32'h0ACC_E551) |=> locked); // R2
  AST_COMMIT_GUARDED: assert property (@(posedge clk) disable iff (rst)
    !(wr_commit && !locked) |=> $stable(commit_q)); // R4
  AST_ALT_MASKED: assert property (@(posedge clk) disable iff (rst)
    wr_alt |=> ((alt_q ^ $past(alt_q)) & ~$past(commit_q)) == '0); // R5
  AST_RESET_STATE: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (locked && commit_q == 8'hFF && alt_q == 8'h00)); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_lock |=> $stable(locked)); // R7
  AST_ALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_alt |=> $stable(alt_q)); // R8
  AST_ALT_OUT: assert property (@(posedge clk) disable iff (rst)
    alt_sel == alt_q); // R9
endmodule

bind gpio_commit_guard gcg_checker u_chk (
  .clk(clk), .rst(rst), .bus_wdata(bus_wdata),
  .wr_lock(wr_lock), .wr_commit(wr_commit), .wr_alt(wr_alt),
  .locked(locked), .commit_q(commit_q), .alt_q(alt_q), .alt_sel(alt_sel)
);

// File: tb/gpio_commit_guard_tb.sv
module gpio_commit_guard_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  alt_sel;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state
  bit       m_locked = 1;
  bit [7:0] m_commit = 8'hFF;
  bit [7:0] m_alt    = 8'h00;

  gpio_commit_guard u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_sel(alt_sel)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model, stepped at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_locked = 1; m_commit = 8'hFF; m_alt = 8'h00;
    end else if (bus_wr) begin
      case (bus_addr)
        12'h520: m_locked = (bus_wdata != 32'h0ACC_E551);
        12'h524: if (!m_locked) m_commit = bus_wdata[7:0];
        12'h420: for (int i = 0; i < 8; i++) if (m_commit[i]) m_alt[i] = bus_wdata[i];
        default: ;
      endcase
    end
  end

  // per-cycle comparison of the pad output (R9)
  always @(posedge clk) begin
    #2;
    if (!rst && !done) check("R9 alt_sel", {24'h0, alt_sel}, {24'h0, m_alt});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] ref_read(input logic [11:0] a);
    case (a)
      12'h520: return {31'h0, m_locked};
      12'h524: return {24'h0, m_commit};
      12'h420: return {24'h0, m_alt};
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
    check({tag, " model"}, bus_rdata, ref_read(a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 reset state, R3 lock read
    rd("R6 R3 lock after reset", 12'h520, 32'h1);
    rd("R6 commit after reset", 12'h524, 32'hFF);
    rd("R6 alt after reset", 12'h420, 32'h0);
    // R5 full mask passes all bits
    wr(12'h420, 32'hFFFF_FFA5);
    rd("R5 full-mask write", 12'h420, 32'hA5);
    // R4 commit ignored while locked
    wr(12'h524, 32'h0F);
    rd("R4 commit locked", 12'h524, 32'hFF);
    // R1 unlock
    wr(12'h520, 32'h0ACC_E551);
    rd("R1 R3 unlocked", 12'h520, 32'h0);
    // R4 low byte stored
    wr(12'h524, 32'hABCD_123C);
    rd("R4 commit low byte", 12'h524, 32'h3C);
    rd("R7 still unlocked after commit", 12'h520, 32'h0);
    // R5 partial mask: A5 -> (A5 & C3) | (00 & 3C) = 81
    wr(12'h420, 32'h0);
    rd("R5 masked clear", 12'h420, 32'h81);
    wr(12'h420, 32'hFF);
    rd("R5 masked set", 12'h420, 32'hBD);
    rd("R7 unlocked after alt write", 12'h520, 32'h0);
    // R8 writes elsewhere
    wr(12'h528, 32'h0);
    wr(12'h41C, 32'h0);
    wr(12'h521, 32'h1234);
    wr(12'h424, 32'h0);
    rd("R8 lock untouched", 12'h520, 32'h0);
    rd("R8 commit untouched", 12'h524, 32'h3C);
    rd("R8 alt untouched", 12'h420, 32'hBD);
    // R10 unmapped reads
    rd("R10 unmapped 0x528", 12'h528, 32'h0);
    rd("R10 unmapped 0x000", 12'h000, 32'h0);
    // R2 near-miss key locks
    wr(12'h520, 32'h0ACC_E550);
    rd("R2 bit0 miss", 12'h520, 32'h1);
    wr(12'h524, 32'h00);
    rd("R4 commit refused after relock", 12'h524, 32'h3C);
    wr(12'h520, 32'h0ACC_E551);
    wr(12'h520, 32'h1ACC_E551);
    rd("R2 upper-bit miss", 12'h520, 32'h1);
    // R7 key twice stays unlocked, then zero mask freezes alt
    wr(12'h520, 32'h0ACC_E551);
    wr(12'h520, 32'h0ACC_E551);
    rd("R7 repeated key", 12'h520, 32'h0);
    wr(12'h524, 32'h00);
    wr(12'h520, 32'h0);
    rd("R2 zero locks", 12'h520, 32'h1);
    wr(12'h420, 32'h42);
    rd("R5 zero mask freezes", 12'h420, 32'hBD);
    // R6 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd("R6 lock after reset", 12'h520, 32'h1);
    rd("R6 commit after reset", 12'h524, 32'hFF);
    rd("R6 alt after reset", 12'h420, 32'h0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule